// File: doc/BRIEF.md
# Character Row Sequencer with Badline Control

This block runs the per-scanline character row logic of a text-mode video controller. It holds a 3-bit row counter, a video counter base that marks where the current text row starts in screen memory, and a flag that says whether the sequencer is in display or idle mode. On every cycle it evaluates the badline condition: the raster line lies inside the display window and its low three bits equal a programmable vertical scroll value. On a badline the block asks the CPU to stall and produces a load strobe for each of the 40 row-buffer entries. Each entry holds 12 bits, because screen and colour data arrive together in one cycle. The row buffer itself is outside the block.

The surrounding raster logic supplies the raster line and the cycle within the line, numbered 1 to 63. Each counter update happens at the clock edge that ends the cycle named below. The scroll register can be rewritten at any time. A write counts in the same cycle it is made, so software can create a badline mid-line and fetch a new row on any line. The same write can cancel a badline before the end-of-row decision. Forcing a badline while the row counter is 7 repeats a row: the base advances, the sequencer stays in display mode, the counter wraps to 0, and no new data is fetched.

Top module: `crs_row_sequencer`

## Requirements
- R1: While reset is active, the row counter and the video counter base go to 0 and the mode flag goes to idle (0). The scroll register reloads to 3.
- R2: `badline` is 1 exactly when the raster line is between 48 and 247 inclusive and its bits [2:0] equal the scroll value. A write in a cycle uses the written value in that same cycle.
- R3: `stall_req` is 1 only in cycles 12 to 54 of a line, and only while `badline` is 1.
- R4: `rowbuf_load` is 1 in cycles 15 to 54 when `badline` and `fetch_ack` are both 1. `rowbuf_index` then equals cycle minus 15. Otherwise `rowbuf_load` is 0 and `rowbuf_index` is 0.
- R5: A badline in any cycle sets the mode flag to display (1) from the next cycle on.
- R6: A badline in cycle 14 clears the row counter to 0.
- R7: In cycle 58, in display mode with the row counter below 7, the row counter increments by one.
- R8: In cycle 58, with the row counter at 7 and no badline, the base takes the video counter and the mode goes to idle. The row counter stays at 7. A badline raised earlier in the line and cancelled before cycle 58 ends this way.
- R9: In cycle 58, with the row counter at 7 and a badline present, the base takes the video counter, the mode stays display and the row counter wraps to 0. The following non-badline line displays with no row-buffer loads.
- R10: In idle mode with no badline, the row counter and the base hold their values.
- R11: The video counter reloads from the base in cycle 14 and counts once per cycle over cycles 15 to 54 in display mode, so each displayed row advances the base by 40.
- R12: In cycle 1 of raster line 0, the base clears to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per line cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| raster_line | input | 9 | Current raster line |
| line_cycle | input | 7 | Cycle within the line, 1 to 63 |
| scroll_we | input | 1 | Write strobe for the vertical scroll value |
| scroll_wdata | input | 3 | New vertical scroll value |
| fetch_ack | input | 1 | Pulse: a 12-bit character word has arrived |
| badline | output | 1 | Badline condition for this cycle |
| stall_req | output | 1 | Request to hold the CPU off the bus |
| rowbuf_load | output | 1 | Write enable for one row-buffer entry |
| rowbuf_index | output | 6 | Row-buffer entry being written |
| row_cnt | output | 3 | Row counter |
| vc_base | output | 10 | Video counter base |
| display_mode | output | 1 | 1 = display mode, 0 = idle |

## Verification
The bench forces a badline at cycle 55 of a row-7 line. A design that decides the row end before checking the badline would drop to idle there instead of repeating the row. The following line must show no row-buffer loads and a base that advanced by 40; a design that fetches again or keeps the old base fails these checks. The bench also raises a badline mid-line and cancels it before cycle 58. A design that latches a badline instead of sampling it in the decision cycle would stay in display mode. The bench then checks the window edges at lines 47, 48, 247 and 248, and a write that counts in its own cycle. A design that uses the old scroll value, or gets a window bound off by one, fails these checks.

// File: rtl/crs_pkg.sv
// Package crs_pkg
// Shared types of the character row sequencer.
// Assumes: the mode flag is one bit with idle encoded as 0.
package crs_pkg;

    typedef enum logic {
        MODE_IDLE    = 1'b0,
        MODE_DISPLAY = 1'b1
    } seq_mode_e;

endpackage

// File: rtl/crs_cycle_decode.sv
// Module crs_cycle_decode
// Turns the raster line and the cycle within the line into the strobes the
// sequencer needs: video counter reload, fetch window, stall window,
// end-of-row decision and start of frame.
// Assumes: line_cycle counts from 1 and FETCH_FIRST > STALL_LEAD.
module crs_cycle_decode #(
    parameter int LINE_W       = 9,
    parameter int CYC_W        = 7,
    parameter int IDX_W        = 6,
    parameter int NUM_COLS     = 40,
    parameter int FETCH_FIRST  = 15,
    parameter int STALL_LEAD   = 3,
    parameter int DECIDE_CYCLE = 58,
    parameter int FRAME_LINE   = 0,
    parameter int FRAME_CYCLE  = 1
) (
    input  logic [LINE_W-1:0] raster_line,
    input  logic [CYC_W-1:0]  line_cycle,
    output logic              at_vc_load,
    output logic              in_fetch,
    output logic              in_stall,
    output logic              at_decide,
    output logic              at_frame_start,
    output logic [IDX_W-1:0]  fetch_index
);

    localparam logic [CYC_W-1:0]  FETCH_FIRST_C = CYC_W'(FETCH_FIRST);
    localparam logic [CYC_W-1:0]  FETCH_LAST_C  = CYC_W'(FETCH_FIRST + NUM_COLS - 1);
    localparam logic [CYC_W-1:0]  STALL_FIRST_C = CYC_W'(FETCH_FIRST - STALL_LEAD);
    localparam logic [CYC_W-1:0]  VC_LOAD_C     = CYC_W'(FETCH_FIRST - 1);
    localparam logic [CYC_W-1:0]  DECIDE_C      = CYC_W'(DECIDE_CYCLE);
    localparam logic [CYC_W-1:0]  FRAME_CYC_C   = CYC_W'(FRAME_CYCLE);
    localparam logic [LINE_W-1:0] FRAME_LINE_C  = LINE_W'(FRAME_LINE);

    // Purpose: compare the cycle position against the fixed event points.
    always_comb begin
        at_vc_load     = (line_cycle == VC_LOAD_C);
        in_fetch       = (line_cycle >= FETCH_FIRST_C) && (line_cycle <= FETCH_LAST_C);
        in_stall       = (line_cycle >= STALL_FIRST_C) && (line_cycle <= FETCH_LAST_C);
        at_decide      = (line_cycle == DECIDE_C);
        at_frame_start = (line_cycle == FRAME_CYC_C) && (raster_line == FRAME_LINE_C);
        fetch_index    = in_fetch ? IDX_W'(line_cycle - FETCH_FIRST_C) : '0;
    end

endmodule

// File: rtl/crs_badline_eval.sv
// Module crs_badline_eval
// Holds the vertical scroll register and evaluates the badline condition
// every cycle. A write is bypassed so it counts in the cycle it is made.
// Drives the CPU stall request and the row-buffer load strobe.
// Assumes: the scroll value is RC_W bits wide and matched against the low
// bits of the raster line.
module crs_badline_eval #(
    parameter int LINE_W       = 9,
    parameter int RC_W         = 3,
    parameter int IDX_W        = 6,
    parameter int WIN_FIRST    = 48,
    parameter int WIN_LAST     = 247,
    parameter int RESET_SCROLL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] raster_line,
    input  logic              scroll_we,
    input  logic [RC_W-1:0]   scroll_wdata,
    input  logic              fetch_ack,
    input  logic              in_fetch,
    input  logic              in_stall,
    input  logic [IDX_W-1:0]  fetch_index,
    output logic              badline,
    output logic              stall_req,
    output logic              rowbuf_load,
    output logic [IDX_W-1:0]  rowbuf_index
);

    localparam logic [LINE_W-1:0] WIN_FIRST_C = LINE_W'(WIN_FIRST);
    localparam logic [LINE_W-1:0] WIN_LAST_C  = LINE_W'(WIN_LAST);
    localparam logic [RC_W-1:0]   SCROLL_RST  = RC_W'(RESET_SCROLL);

    logic [RC_W-1:0] scroll_q;
    logic [RC_W-1:0] scroll_now;
    logic            in_window;

    // Purpose: store the vertical scroll value written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scroll_q <= SCROLL_RST;
        end else if (scroll_we) begin
            scroll_q <= scroll_wdata;
        end
    end

    // Purpose: evaluate the badline condition with same-cycle write bypass.
    always_comb begin
        scroll_now = scroll_we ? scroll_wdata : scroll_q;
        in_window  = (raster_line >= WIN_FIRST_C) && (raster_line <= WIN_LAST_C);
        badline    = in_window && (raster_line[RC_W-1:0] == scroll_now);
    end

    // Purpose: derive the stall request and the row-buffer write strobe.
    always_comb begin
        stall_req    = badline && in_stall;
        rowbuf_load  = badline && in_fetch && fetch_ack;
        rowbuf_index = rowbuf_load ? fetch_index : '0;
    end

endmodule

// File: rtl/crs_row_counter.sv
// Module crs_row_counter
// Keeps the row counter and the display/idle mode flag. A badline forces
// display mode. The counter clears at the reload cycle of a badline and
// steps at the decision cycle. With the counter at its last value and no
// badline, the row ends in idle mode.
// Assumes: at_vc_load and at_decide are never true in the same cycle.
module crs_row_counter
    import crs_pkg::*;
#(
    parameter int RC_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            badline,
    input  logic            at_vc_load,
    input  logic            at_decide,
    output logic [RC_W-1:0] row_cnt,
    output seq_mode_e       mode,
    output logic            row_last
);

    localparam logic [RC_W-1:0] RC_MAX = '1;

    logic [RC_W-1:0] rc_q;
    seq_mode_e       mode_q;
    logic            go_idle;

    // Purpose: flag the last row and the condition that ends it in idle mode.
    always_comb begin
        row_last = (rc_q == RC_MAX);
        go_idle  = at_decide && row_last && !badline;
    end

    // Purpose: update the row counter and the mode flag once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rc_q   <= '0;
            mode_q <= MODE_IDLE;
        end else begin
            if (badline) begin
                mode_q <= MODE_DISPLAY;
            end else if (go_idle) begin
                mode_q <= MODE_IDLE;
            end
            if (at_vc_load && badline) begin
                rc_q <= '0;
            end else if (at_decide && (mode_q == MODE_DISPLAY) && !go_idle) begin
                rc_q <= rc_q + 1'b1;
            end
        end
    end

    assign row_cnt = rc_q;
    assign mode    = mode_q;

endmodule

// File: rtl/crs_video_counter.sv
// Module crs_video_counter
// Keeps the running video counter and its base. The counter reloads from
// the base before the fetch window and counts each displayed column. The
// base takes the counter at the end of a character row and clears at the
// start of a frame.
// Assumes: the frame start cycle never matches the decision cycle.
module crs_video_counter
    import crs_pkg::*;
#(
    parameter int VC_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            at_vc_load,
    input  logic            in_fetch,
    input  logic            at_decide,
    input  logic            at_frame_start,
    input  logic            row_last,
    input  seq_mode_e       mode,
    output logic [VC_W-1:0] vc_base
);

    logic [VC_W-1:0] vc_q;
    logic [VC_W-1:0] base_q;

    // Purpose: reload the counter from the base or step it per displayed column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vc_q <= '0;
        end else if (at_vc_load) begin
            vc_q <= base_q;
        end else if (in_fetch && (mode == MODE_DISPLAY)) begin
            vc_q <= vc_q + 1'b1;
        end
    end

    // Purpose: latch the row start address at the row end, clear it per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (at_frame_start) begin
            base_q <= '0;
        end else if (at_decide && row_last) begin
            base_q <= vc_q;
        end
    end

    assign vc_base = base_q;

endmodule

// File: rtl/crs_row_sequencer.sv
// Module crs_row_sequencer (top)
// Character row sequencer of a text-mode video controller. It combines the
// cycle decoder, the badline evaluator, the row counter and the video
// counter. Each register update takes effect at the clock edge that ends
// the cycle named by line_cycle.
// Assumes: line_cycle runs 1..63 and raster_line is steady within a line.
module crs_row_sequencer
    import crs_pkg::*;
#(
    parameter int LINE_W       = 9,
    parameter int CYC_W        = 7,
    parameter int VC_W         = 10,
    parameter int RC_W         = 3,
    parameter int NUM_COLS     = 40,
    parameter int FETCH_FIRST  = 15,
    parameter int STALL_LEAD   = 3,
    parameter int DECIDE_CYCLE = 58,
    parameter int WIN_FIRST    = 48,
    parameter int WIN_LAST     = 247,
    parameter int RESET_SCROLL = 3,
    parameter int FRAME_LINE   = 0,
    parameter int FRAME_CYCLE  = 1,
    localparam int IDX_W       = $clog2(NUM_COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] raster_line,
    input  logic [CYC_W-1:0]  line_cycle,
    input  logic              scroll_we,
    input  logic [RC_W-1:0]   scroll_wdata,
    input  logic              fetch_ack,
    output logic              badline,
    output logic              stall_req,
    output logic              rowbuf_load,
    output logic [IDX_W-1:0]  rowbuf_index,
    output logic [RC_W-1:0]   row_cnt,
    output logic [VC_W-1:0]   vc_base,
    output logic              display_mode
);

    logic             at_vc_load;
    logic             in_fetch;
    logic             in_stall;
    logic             at_decide;
    logic             at_frame_start;
    logic [IDX_W-1:0] fetch_index;
    logic             row_last;
    seq_mode_e        mode;

    crs_cycle_decode #(
        .LINE_W      (LINE_W),
        .CYC_W       (CYC_W),
        .IDX_W       (IDX_W),
        .NUM_COLS    (NUM_COLS),
        .FETCH_FIRST (FETCH_FIRST),
        .STALL_LEAD  (STALL_LEAD),
        .DECIDE_CYCLE(DECIDE_CYCLE),
        .FRAME_LINE  (FRAME_LINE),
        .FRAME_CYCLE (FRAME_CYCLE)
    ) decode_i (
        .raster_line   (raster_line),
        .line_cycle    (line_cycle),
        .at_vc_load    (at_vc_load),
        .in_fetch      (in_fetch),
        .in_stall      (in_stall),
        .at_decide     (at_decide),
        .at_frame_start(at_frame_start),
        .fetch_index   (fetch_index)
    );

    crs_badline_eval #(
        .LINE_W      (LINE_W),
        .RC_W        (RC_W),
        .IDX_W       (IDX_W),
        .WIN_FIRST   (WIN_FIRST),
        .WIN_LAST    (WIN_LAST),
        .RESET_SCROLL(RESET_SCROLL)
    ) badline_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .raster_line (raster_line),
        .scroll_we   (scroll_we),
        .scroll_wdata(scroll_wdata),
        .fetch_ack   (fetch_ack),
        .in_fetch    (in_fetch),
        .in_stall    (in_stall),
        .fetch_index (fetch_index),
        .badline     (badline),
        .stall_req   (stall_req),
        .rowbuf_load (rowbuf_load),
        .rowbuf_index(rowbuf_index)
    );

    crs_row_counter #(
        .RC_W(RC_W)
    ) rowcnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .badline   (badline),
        .at_vc_load(at_vc_load),
        .at_decide (at_decide),
        .row_cnt   (row_cnt),
        .mode      (mode),
        .row_last  (row_last)
    );

    crs_video_counter #(
        .VC_W(VC_W)
    ) vidcnt_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .at_vc_load    (at_vc_load),
        .in_fetch      (in_fetch),
        .at_decide     (at_decide),
        .at_frame_start(at_frame_start),
        .row_last      (row_last),
        .mode          (mode),
        .vc_base       (vc_base)
    );

    assign display_mode = (mode == MODE_DISPLAY);

endmodule

// File: rtl/crs_row_sequencer_chk.sv
// Module crs_row_sequencer_chk
// Checker bound to crs_row_sequencer. It relates the port behaviour over
// time to the requirements.
// Assumes: the top is used with its default timing parameters.
module crs_row_sequencer_chk #(
    parameter int CYC_W = 7,
    parameter int RC_W  = 3,
    parameter int VC_W  = 10,
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CYC_W-1:0] line_cycle,
    input logic             badline,
    input logic             stall_req,
    input logic             rowbuf_load,
    input logic [IDX_W-1:0] rowbuf_index,
    input logic [RC_W-1:0]  row_cnt,
    input logic [VC_W-1:0]  vc_base,
    input logic             display_mode
);

    assert_stall_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> (badline && line_cycle >= 7'd12 && line_cycle <= 7'd54));

    assert_load_inside_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rowbuf_load |-> (stall_req && line_cycle >= 7'd15));

    assert_index_zero_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rowbuf_load |-> (rowbuf_index == '0));

    assert_badline_display_R5: assert property (@(posedge clk) disable iff (!rst_n)
        badline |=> display_mode);

    assert_rc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (badline && line_cycle == 7'd14) |=> (row_cnt == '0));

    assert_rc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (display_mode && line_cycle == 7'd58 && row_cnt != 3'd7)
        |=> (row_cnt == 3'($past(row_cnt) + 3'd1)));

    assert_row_end_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_cycle == 7'd58 && row_cnt == 3'd7 && !badline) |=> !display_mode);

    assert_repeat_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_cycle == 7'd58 && row_cnt == 3'd7 && badline) |=> (display_mode && row_cnt == '0));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!display_mode && !badline) |=> $stable(row_cnt));

    assert_base_only_at_events_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (line_cycle != 7'd58 && line_cycle != 7'd1) |=> $stable(vc_base));

endmodule

bind crs_row_sequencer crs_row_sequencer_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_cycle  (line_cycle),
    .badline     (badline),
    .stall_req   (stall_req),
    .rowbuf_load (rowbuf_load),
    .rowbuf_index(rowbuf_index),
    .row_cnt     (row_cnt),
    .vc_base     (vc_base),
    .display_mode(display_mode)
);

// File: tb/crs_row_sequencer_tb.sv
// Directed bench for crs_row_sequencer: one task per scenario.
module crs_row_sequencer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] raster_line = '0;
    logic [6:0] line_cycle = 7'd1;
    logic       scroll_we = 1'b0;
    logic [2:0] scroll_wdata = '0;
    logic       fetch_ack = 1'b0;
    logic       badline;
    logic       stall_req;
    logic       rowbuf_load;
    logic [5:0] rowbuf_index;
    logic [2:0] row_cnt;
    logic [9:0] vc_base;
    logic       display_mode;

    int n_checks = 0;
    int n_fails  = 0;
    int n_clocks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    crs_row_sequencer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .raster_line (raster_line),
        .line_cycle  (line_cycle),
        .scroll_we   (scroll_we),
        .scroll_wdata(scroll_wdata),
        .fetch_ack   (fetch_ack),
        .badline     (badline),
        .stall_req   (stall_req),
        .rowbuf_load (rowbuf_load),
        .rowbuf_index(rowbuf_index),
        .row_cnt     (row_cnt),
        .vc_base     (vc_base),
        .display_mode(display_mode)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    // Drive one cycle's inputs at the falling edge; outputs settle 1 ns later.
    task automatic tick(input logic [8:0] ln, input logic [6:0] cy, input logic we,
                        input logic [2:0] wd, input logic ack);
        @(negedge clk);
        raster_line  = ln;
        line_cycle   = cy;
        scroll_we    = we;
        scroll_wdata = wd;
        fetch_ack    = ack;
        #1;
    endtask

    // Wait until the last edge of a line has updated the registers.
    task automatic line_done();
        @(posedge clk);
        #2;
    endtask

    task automatic plain_line(input logic [8:0] ln);
        for (int c = 1; c <= 63; c++) tick(ln, 7'(c), 1'b0, 3'd0, 1'b1);
        line_done();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk("R1", "row_cnt after reset", int'(row_cnt), 0);
        chk("R1", "vc_base after reset", int'(vc_base), 0);
        chk("R1", "mode after reset", int'(display_mode), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_first_row();
        for (int c = 1; c <= 63; c++) begin
            tick(9'h033, 7'(c), 1'b0, 3'd0, c[0]);
            if (c == 1)  chk("R2", "badline line 0x33 scroll 3", int'(badline), 1);
            if (c == 11) chk("R3", "stall cycle 11", int'(stall_req), 0);
            if (c == 12) chk("R3", "stall cycle 12", int'(stall_req), 1);
            if (c == 54) chk("R3", "stall cycle 54", int'(stall_req), 1);
            if (c == 55) chk("R3", "stall cycle 55", int'(stall_req), 0);
            if (c == 2)  chk("R5", "display after badline", int'(display_mode), 1);
            if (c == 13) chk("R4", "load cycle 13", int'(rowbuf_load), 0);
            if (c == 15) begin
                chk("R4", "load cycle 15", int'(rowbuf_load), 1);
                chk("R4", "index cycle 15", int'(rowbuf_index), 0);
            end
            if (c == 16) chk("R4", "load without ack", int'(rowbuf_load), 0);
            if (c == 53) begin
                chk("R4", "load cycle 53", int'(rowbuf_load), 1);
                chk("R4", "index cycle 53", int'(rowbuf_index), 38);
            end
            if (c == 55) chk("R4", "load cycle 55", int'(rowbuf_load), 0);
        end
        line_done();
        chk("R7", "row_cnt after first row line", int'(row_cnt), 1);
        chk("R11", "vc_base unchanged mid row", int'(vc_base), 0);
    endtask

    task automatic t_walk_and_repeat();
        for (int k = 0; k < 6; k++) begin
            plain_line(9'(9'h034 + k));
            chk("R7", "row_cnt walk", int'(row_cnt), 2 + k);
        end
        for (int c = 1; c <= 63; c++) begin
            tick(9'h03A, 7'(c), (c == 55), 3'd2, 1'b1);
            if (c == 54) chk("R2", "no badline before write", int'(badline), 0);
            if (c == 55) begin
                chk("R2", "badline in write cycle", int'(badline), 1);
                chk("R3", "no stall at cycle 55", int'(stall_req), 0);
            end
        end
        line_done();
        chk("R9", "row_cnt wraps on repeat", int'(row_cnt), 0);
        chk("R9", "stays display on repeat", int'(display_mode), 1);
        chk("R11", "base advanced by 40", int'(vc_base), 40);
    endtask

    task automatic t_repeat_display();
        int loads = 0;
        for (int c = 1; c <= 63; c++) begin
            tick(9'h03B, 7'(c), 1'b0, 3'd0, 1'b1);
            if (rowbuf_load) loads++;
        end
        line_done();
        chk("R9", "no row-buffer loads on repeated row", loads, 0);
        chk("R9", "display kept on repeated row", int'(display_mode), 1);
        chk("R7", "row_cnt after repeated row", int'(row_cnt), 1);
        chk("R9", "base holds", int'(vc_base), 40);
    endtask

    task automatic t_abort_to_idle();
        for (int c = 1; c <= 63; c++) tick(9'h03C, 7'(c), (c == 1), 3'd3, 1'b1);
        line_done();
        for (int k = 1; k <= 5; k++) plain_line(9'(9'h03C + k));
        chk("R7", "row_cnt before abort line", int'(row_cnt), 7);
        for (int c = 1; c <= 63; c++) begin
            tick(9'h042, 7'(c), (c == 30 || c == 50), (c == 30) ? 3'd2 : 3'd3, 1'b1);
            if (c == 29) chk("R3", "stall before forced badline", int'(stall_req), 0);
            if (c == 30) chk("R3", "stall at forced badline", int'(stall_req), 1);
            if (c == 50) chk("R3", "stall after cancel", int'(stall_req), 0);
        end
        line_done();
        chk("R8", "idle after cancelled badline", int'(display_mode), 0);
        chk("R8", "row_cnt holds at 7", int'(row_cnt), 7);
        chk("R11", "base takes counter", int'(vc_base), 80);
    endtask

    task automatic t_idle_hold();
        int bl = 0;
        plain_line(9'h0F9);
        chk("R10", "row_cnt idle hold", int'(row_cnt), 7);
        chk("R10", "mode idle hold", int'(display_mode), 0);
        chk("R10", "base idle hold", int'(vc_base), 80);
        for (int c = 1; c <= 63; c++) begin
            tick(9'h0FB, 7'(c), 1'b0, 3'd0, 1'b1);
            if (badline || stall_req) bl++;
        end
        line_done();
        chk("R2", "no badline outside window", bl, 0);
    endtask

    task automatic t_frame_start();
        plain_line(9'h000);
        chk("R12", "base cleared at frame start", int'(vc_base), 0);
        chk("R10", "row_cnt across frame start", int'(row_cnt), 7);
    endtask

    task automatic t_late_entry();
        for (int c = 1; c <= 63; c++) begin
            tick(9'h04B, 7'(c), 1'b0, 3'd0, 1'b1);
            if (c == 2)  chk("R5", "display from idle", int'(display_mode), 1);
            if (c == 14) chk("R6", "row_cnt before clear", int'(row_cnt), 7);
            if (c == 15) chk("R6", "row_cnt cleared", int'(row_cnt), 0);
        end
        line_done();
        chk("R7", "row_cnt after entry line", int'(row_cnt), 1);
    endtask

    task automatic t_window_edges();
        tick(9'h02F, 7'd1, 1'b1, 3'd7, 1'b0);
        chk("R2", "line 47 excluded", int'(badline), 0);
        tick(9'h030, 7'd1, 1'b1, 3'd0, 1'b0);
        chk("R2", "line 48 included", int'(badline), 1);
        tick(9'h0F7, 7'd1, 1'b1, 3'd7, 1'b0);
        chk("R2", "line 247 included", int'(badline), 1);
        tick(9'h0F8, 7'd1, 1'b1, 3'd0, 1'b0);
        chk("R2", "line 248 excluded", int'(badline), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        n_clocks++;
        if (n_clocks >= 200000 && !finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", n_clocks);
            summary();
        end
    end

    initial begin
        t_reset();
        t_first_row();
        t_walk_and_repeat();
        t_repeat_display();
        t_abort_to_idle();
        t_idle_hold();
        t_frame_start();
        t_late_entry();
        t_window_edges();
        summary();
    end

endmodule